// File: doc/BRIEF.md
# Spare-column repair controller

This controller restores a programmable AND array after a product-term column has been found faulty. Each column belongs to an OR group. Each group holds a number of base columns and a smaller set of spare columns. The controller keeps a two-bit status for every column: available spare, in use, or retired. When the diagnoser names a faulty column, the controller picks a spare from the same group and moves the column's expected configuration into it. It then programs the spare and neutralises the failed column by programming every cross-point of that column ON.

The expected configuration sits in an external memory that holds one word per column, with one bit per array input. Its read data arrives one cycle after the address. Reprogramming goes through a command port that carries a column index and its cross-point data. A command is held until the array acknowledges it. Once a column has been moved, the controller asks for a fresh diagnosis, so a spare that proves faulty can itself be retired and replaced. A group that cannot mask a fault raises a sticky go/no-go fault.

Columns are numbered group by group. Column `c` belongs to group `c / (BASE+SPARE)`. Inside its group, the first `BASE` positions are base columns and the rest are spares.

Top module: `spare_col_repair`

## Requirements
- R1: After reset every base column is in use and every spare is available (status codes: 01 available, 00 in use, 11 retired, and 10 never occurs), and `busy`, `done`, `nogo`, `mem_we` and `prog_valid` are all low.
- R2: A fault on an in-use column takes the lowest-numbered available spare of that column's own group.
- R3: A repair performs these steps in this order: read the faulty column's word, write it to the spare's word, program the spare with it, write all ones to the faulty column's word, and program the faulty column with all ones. Each program command keeps its column and data steady until `prog_done`.
- R4: After a repair the faulty column becomes retired and the spare becomes in use. A later fault on that spare moves it onto the next available spare, and a retired column is never chosen again.
- R5: A fault on an in-use column whose group has no available spare raises `nogo` at the same edge that starts the `done` pulse, with no memory write and no program command. `nogo` stays high until reset.
- R6: A fault on an available spare retires it without any memory write or program command, so later repairs skip it.
- R7: A fault on a retired column changes nothing: no write, no command, and no change to `nogo`.
- R8: Every accepted request ends with a one-cycle `done` pulse. `rediag` is high together with `done` only when a column was actually moved onto a spare.
- R9: `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Faulty-column report from the diagnoser |
| req_col | input | CW | Index of the faulty column |
| busy | output | 1 | A request is being handled |
| done | output | 1 | One-cycle end-of-request pulse |
| rediag | output | 1 | Request for a new diagnosis pass |
| nogo | output | 1 | Sticky global fault: a fault could not be masked |
| mem_addr | output | CW | Configuration memory column address |
| mem_we | output | 1 | Configuration memory write enable |
| mem_wdata | output | ROWS | Configuration memory write data |
| mem_rdata | input | ROWS | Configuration memory read data (one cycle after address) |
| prog_valid | output | 1 | Reprogram command valid |
| prog_col | output | CW | Column to reprogram |
| prog_data | output | ROWS | Cross-point data for that column |
| prog_done | input | 1 | Array acknowledges the reprogram command |

## Verification
A wrong column status only shows up at the next request that touches the same group. It can appear as the wrong spare index on `prog_col`, a missing or extra command, or `nogo` rising too early or too late. For that reason the bench chains requests within each group, including a second fault on a spare that has just been used and a fault on an unused spare, so that a stale status is seen within one or two requests. A wrong step order or wrong data shows at once in the command sequence and in the memory image, which the bench compares after every `done`.

// File: rtl/spare_col_repair.sv
module spare_col_repair #(
  parameter int ROWS = 8,
  parameter int GROUPS = 2,
  parameter int BASE = 3,
  parameter int SPARE = 2,
  localparam int COLS_PER = BASE + SPARE,
  localparam int NCOL = GROUPS * COLS_PER,
  localparam int CW = $clog2(NCOL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [CW-1:0]   req_col,
  output logic            busy,
  output logic            done,
  output logic            rediag,
  output logic            nogo,
  output logic [CW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [ROWS-1:0] mem_wdata,
  input  logic [ROWS-1:0] mem_rdata,
  output logic            prog_valid,
  output logic [CW-1:0]   prog_col,
  output logic [ROWS-1:0] prog_data,
  input  logic            prog_done
);
  localparam logic [1:0] ST_AVAIL = 2'b01;
  localparam logic [1:0] ST_USED  = 2'b00;
  localparam logic [1:0] ST_DEAD  = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CPY, S_PSP, S_WFL, S_PFL, S_DONE} state_t;

  state_t state;
  logic [CW-1:0] fcol, scol, pick;
  logic [ROWS-1:0] cdata;
  logic repaired, found, req_ok;
  logic [1:0] cur;
  logic [NCOL-1:0][1:0] st;

  assign req_ok = int'(req_col) < NCOL;
  assign cur = req_ok ? st[req_col] : ST_DEAD;

  always_comb begin
    found = 1'b0;
    pick = '0;
    for (int k = SPARE - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(req_col) / COLS_PER) * COLS_PER + BASE + k;
      if (idx < NCOL && st[CW'(idx)] == ST_AVAIL) begin
        found = 1'b1;
        pick = CW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      nogo <= 1'b0;
      repaired <= 1'b0;
      fcol <= '0;
      scol <= '0;
      cdata <= '0;
      for (int c = 0; c < NCOL; c++)
        st[c] <= (c % COLS_PER < BASE) ? ST_USED : ST_AVAIL;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          fcol <= req_col;
          scol <= pick;
          repaired <= 1'b0;
          state <= S_DONE;
          if (req_ok && cur == ST_USED) begin
            if (found) state <= S_RD;
            else nogo <= 1'b1;
          end else if (req_ok && cur == ST_AVAIL) begin
            st[req_col] <= ST_DEAD;
          end
        end
        S_RD:  state <= S_CPY;
        S_CPY: begin
          cdata <= mem_rdata;
          state <= S_PSP;
        end
        S_PSP: if (prog_done) state <= S_WFL;
        S_WFL: state <= S_PFL;
        S_PFL: if (prog_done) begin
          st[fcol] <= ST_DEAD;
          st[scol] <= ST_USED;
          repaired <= 1'b1;
          state <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = state != S_IDLE;
  assign done       = state == S_DONE;
  assign rediag     = done && repaired;
  assign mem_addr   = (state == S_CPY) ? scol : fcol;
  assign mem_we     = (state == S_CPY) || (state == S_WFL);
  assign mem_wdata  = (state == S_CPY) ? mem_rdata : '1;
  assign prog_valid = (state == S_PSP) || (state == S_PFL);
  assign prog_col   = (state == S_PSP) ? scol : fcol;
  assign prog_data  = (state == S_PSP) ? cdata : '1;
endmodule

// File: rtl/spare_col_repair_chk.sv
module spare_col_repair_chk #(
  parameter int ROWS = 8,
  parameter int NCOL = 10,
  parameter int CW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 done,
  input logic                 rediag,
  input logic                 nogo,
  input logic                 mem_we,
  input logic                 prog_valid,
  input logic [CW-1:0]        prog_col,
  input logic [ROWS-1:0]      prog_data,
  input logic                 prog_done,
  input logic [NCOL-1:0][1:0] st
);
  // R3
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid && !prog_done |=> prog_valid && $stable(prog_col) && $stable(prog_data));

  // R5
  nogo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) nogo |=> nogo);

  // R5
  nogo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nogo) |-> done && !mem_we && !prog_valid);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R8
  rediag_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) rediag |-> done);

  // R9
  work_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || prog_valid) |-> busy && !done);

  for (genvar i = 0; i < NCOL; i++) begin : g_col
    // R4
    retired_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st[i] == 2'b11 |=> st[i] == 2'b11);
    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n) st[i] != 2'b10);
  end
endmodule

bind spare_col_repair spare_col_repair_chk #(.ROWS(ROWS), .NCOL(NCOL), .CW(CW)) u_chk (.*);

// File: tb/spare_col_repair_test.sv
module spare_col_repair_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8, GROUPS = 2, BASE = 3, SPARE = 2;
  localparam int COLS_PER = BASE + SPARE;
  localparam int NCOL = GROUPS * COLS_PER;
  localparam int CW = $clog2(NCOL);

  logic clk = 0, rst_n = 0, req_valid = 0, prog_done = 0;
  logic [CW-1:0] req_col = '0;
  logic busy, done, rediag, nogo, mem_we, prog_valid;
  logic [CW-1:0] mem_addr, prog_col;
  logic [ROWS-1:0] mem_wdata, mem_rdata, prog_data;

  logic [ROWS-1:0] mem [NCOL];
  logic [ROWS-1:0] exp_mem [NCOL];
  int ref_st [NCOL];
  int q_col [$];
  logic [ROWS-1:0] q_dat [$];
  int n_tests = 0, n_fail = 0;
  bit exp_nogo = 0;

  spare_col_repair #(.ROWS(ROWS), .GROUPS(GROUPS), .BASE(BASE), .SPARE(SPARE)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [ROWS-1:0] seed(int i);
    return ROWS'(i * 37 + 5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOL; i++) mem[i] <= seed(i);
      mem_rdata <= '0;
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // responder and monitor: acknowledges commands, pops the scoreboard
  initial begin
    int wc = 0;
    forever begin
      @(negedge clk);
      if (prog_done) prog_done = 0;
      else if (prog_valid) begin
        if (wc == 2) begin
          if (q_col.size() == 0)
            chk(0, "R3", "unexpected program command col", int'(prog_col), -1);
          else begin
            int ec;
            logic [ROWS-1:0] ed;
            ec = q_col.pop_front();
            ed = q_dat.pop_front();
            chk(int'(prog_col) == ec, "R2", "program column", int'(prog_col), ec);
            chk(prog_data == ed, "R3", "program data", int'(prog_data), int'(ed));
          end
          prog_done = 1;
          wc = 0;
        end else wc++;
      end
    end
  end

  task automatic fault(int c, bit intrude, string tag);
    bit exp_rediag = 0;
    int n = 0;
    if (ref_st[c] == 0) begin
      int s = -1;
      int g0 = (c / COLS_PER) * COLS_PER;
      for (int k = BASE; k < COLS_PER; k++)
        if (s < 0 && ref_st[g0 + k] == 1) s = g0 + k;
      if (s >= 0) begin
        q_col.push_back(s);  q_dat.push_back(exp_mem[c]);
        q_col.push_back(c);  q_dat.push_back('1);
        exp_mem[s] = exp_mem[c];
        exp_mem[c] = '1;
        ref_st[c] = -1;
        ref_st[s] = 0;
        exp_rediag = 1;
      end else exp_nogo = 1;
    end else if (ref_st[c] == 1) ref_st[c] = -1;

    @(negedge clk);
    req_valid = 1;
    req_col = CW'(c);
    @(negedge clk);
    req_valid = 0;
    if (intrude) begin
      @(negedge clk);
      req_valid = 1;
      req_col = CW'(5);
      @(negedge clk);
      req_valid = 0;
    end
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(done, {tag, " R8"}, "done seen", int'(done), 1);
    chk(rediag == exp_rediag, {tag, " R8"}, "rediag", int'(rediag), int'(exp_rediag));
    chk(nogo == exp_nogo, {tag, " R5"}, "nogo", int'(nogo), int'(exp_nogo));
    chk(q_col.size() == 0, {tag, " R3"}, "commands left", q_col.size(), 0);
    @(negedge clk);
    chk(!done && !busy, {tag, " R8"}, "done/busy after pulse", int'({done, busy}), 0);
    for (int i = 0; i < NCOL; i++)
      chk(mem[i] == exp_mem[i], tag, $sformatf("memory col %0d", i), int'(mem[i]), int'(exp_mem[i]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCOL; i++) begin
      exp_mem[i] = seed(i);
      ref_st[i] = (i % COLS_PER < BASE) ? 0 : 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !nogo && !prog_valid && !mem_we, "R1", "idle after reset",
        int'({busy, done, nogo, prog_valid, mem_we}), 0);

    fault(1, 1, "R2 R9");     // spare 3; request for col 5 during busy is dropped
    chk(mem[5] == seed(5), "R9", "col 5 untouched", int'(mem[5]), int'(seed(5)));
    fault(6, 0, "R2");        // spare 8, so col 5 was not repaired meanwhile
    fault(1, 0, "R7");        // already retired
    fault(3, 0, "R4");        // used spare fails, moves to 4
    fault(9, 0, "R6");        // unused spare retired
    fault(0, 0, "R5");        // group 0 exhausted
    fault(7, 0, "R6 R5");     // 9 retired, 8 used: no spare
    fault(2, 0, "R5");
    chk(q_col.size() == 0, "R3", "final scoreboard", q_col.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule